// File: doc/BRIEF.md
# Flash Sector Lock Sequencer

This block sits on the host side of a parallel flash device and carries out in-system sector locking and unlocking without software involvement. On a start request it raises the high-voltage reset enable and waits one microsecond. It then walks the sector list, and for each sector it repeats a cycle of a write pulse, a settle wait, a verify write and a readback. The cycle ends when the readback shows the wanted state or when the pulse budget for that pass runs out.

Two modes exist. Lock mode treats only the sectors that the host marks in its sector list. Unlock mode first checks every sector and locks any that still read as open. Once every sector is locked it runs the unlock loop on each sector in turn, with a longer wait and a much larger pulse budget. On success the high voltage is withdrawn and a reset command is written. On failure the sequencer stops with the high voltage off, latches the index of the failing sector, and waits for a new start.

Wait lengths come from a clock frequency parameter, so a simulation can run with short waits.

Top module: `sector_lock_seq`

## Requirements
- R1: After reset the block is idle: high voltage off, chip enable, write strobe and read strobe all high, and busy, done and fail low.
- R2: A start raises the high-voltage enable. No bus write follows until at least ceil(CLK_KHZ*1/1000) cycles have passed, with a minimum of one cycle.
- R3: A lock pulse writes 60h to the sector base with address bit 6 = 0, bit 1 = 1 and bit 0 = 0. After it, a wait of at least ceil(CLK_KHZ*150/1000) cycles passes before the verify write, which is 40h to the same address and is followed by a read.
- R4: A lock verify passes on readback 01h, and the sequencer then moves to the next sector. In lock mode, a sector whose select input is low gets no bus cycle.
- R5: If a lock verify still fails after the 25th pulse, the sequencer stops. fail is set, the failing sector index is latched, the high voltage is off, no reset command is written, and the bus stays idle until the next start.
- R6: In unlock mode each sector is first checked with a verify write (40h, bit 6 = 0) and a read. The lock loop runs only for sectors that do not read 01h.
- R7: An unlock pulse writes 60h with bit 6 = 1, followed by a wait of at least ceil(CLK_KHZ*15000/1000) cycles. The verify write uses 40h with bit 6 = 1, and the readback must be 00h. Up to 1000 pulses are allowed per sector, and the pulse count restarts for each sector.
- R8: On success the high voltage is removed first. Then F0h is written to address 0 with the high voltage low, and done is set.
- R9: In a bus cycle the chip enable is low around a single strobe cycle, the write and read strobes are never low together, and the address stays stable while chip enable is low.
- R10: A start request that arrives while busy is ignored, including a request for the other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when not busy |
| unlock_i | input | 1 | Mode at start: 1 unlock, 0 lock |
| sect_idx_o | output | IDX_W | Sector index being processed |
| sect_base_i | input | ADDR_W | Base address of the indexed sector |
| sect_sel_i | input | 1 | Indexed sector is to be locked (lock mode) |
| flash_addr_o | output | ADDR_W | Flash address |
| flash_dq_o | output | 8 | Flash write data |
| flash_dq_i | input | 8 | Flash read data |
| flash_we_no | output | 1 | Write strobe, active low |
| flash_oe_no | output | 1 | Read strobe, active low |
| flash_ce_no | output | 1 | Chip enable, active low |
| flash_hv_o | output | 1 | High-voltage reset enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed successfully |
| fail_o | output | 1 | Sequence stopped on a failed sector |
| fail_sect_o | output | IDX_W | Index of the failed sector |

## Verification
The case to watch is the readback that passes on the very pulse that uses up the budget. The pass decision and the budget-exhausted decision then fall in the same cycle, and the pass must win. The bench provokes this with a flash model that needs exactly 25 lock pulses, or exactly 1000 unlock pulses, for one sector. It compares this against a sector that needs one pulse more. It judges the outcome by done versus fail, the latched index, and the pulse and verify counts seen on the bus.

// File: rtl/sector_lock_pkg.sv
package sector_lock_pkg;

  localparam int unsigned DQ_W = 8;

  localparam logic [DQ_W-1:0] CMD_PULSE  = 8'h60;
  localparam logic [DQ_W-1:0] CMD_VERIFY = 8'h40;
  localparam logic [DQ_W-1:0] CMD_RESET  = 8'hF0;
  localparam logic [DQ_W-1:0] RD_LOCKED  = 8'h01;
  localparam logic [DQ_W-1:0] RD_OPEN    = 8'h00;

  // address bit that selects the unlock direction
  localparam int unsigned BIT_DIR = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_HV_ON, S_SEL, S_CHK_W, S_CHK_R, S_PLS_W, S_PLS_WAIT,
    S_VFY_W, S_VFY_R, S_NEXT, S_HV_OFF, S_RST_CMD, S_DONE, S_FAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    B_IDLE, B_SETUP, B_STROBE, B_HOLD
  } bus_state_e;

  function automatic int unsigned us_to_cycles(input int unsigned khz,
                                               input int unsigned us);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(khz) * longint'(us);
    cyc  = (prod + 64'd999) / 64'd1000;
    if (cyc == 0) cyc = 1;
    return 32'(cyc);
  endfunction

endpackage

// File: rtl/sector_lock_timer.sv
module sector_lock_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + CNT_W'(1);
  end

  // count never runs past the selected wait
  p_tmr_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && limit_i != '0) |-> (cnt_q < limit_i));

endmodule

// File: rtl/sector_lock_bus.sv
module sector_lock_bus
  import sector_lock_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   wdata_i,
  output logic              ack_o,
  output logic [DQ_W-1:0]   rdata_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DQ_W-1:0]   flash_dq_o,
  input  logic [DQ_W-1:0]   flash_dq_i,
  output logic              flash_we_no,
  output logic              flash_oe_no,
  output logic              flash_ce_no
);

  bus_state_e        st_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   data_q;
  logic [DQ_W-1:0]   rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        B_IDLE: if (req_i) begin
          wr_q   <= wr_i;
          addr_q <= addr_i;
          data_q <= wdata_i;
          st_q   <= B_SETUP;
        end
        B_SETUP:  st_q <= B_STROBE;
        B_STROBE: begin
          if (!wr_q) rdata_q <= flash_dq_i;
          st_q <= B_HOLD;
        end
        B_HOLD:   st_q <= B_IDLE;
        default:  st_q <= B_IDLE;
      endcase
    end
  end

  assign ack_o        = (st_q == B_HOLD);
  assign rdata_o      = rdata_q;
  assign flash_addr_o = addr_q;
  assign flash_dq_o   = data_q;
  assign flash_ce_no  = (st_q == B_IDLE);
  assign flash_we_no  = !((st_q == B_STROBE) && wr_q);
  assign flash_oe_no  = !((st_q == B_STROBE) && !wr_q);

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!flash_we_no && !flash_oe_no));

  p_strobe_ce_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no || !flash_oe_no) |-> !flash_ce_no);

  p_addr_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_ce_no && $past(!flash_ce_no)) |-> $stable(flash_addr_o));

endmodule

// File: rtl/sector_lock_track.sv
module sector_lock_track #(
  parameter int NUM_SECT = 19,
  parameter int IDX_W    = 5,
  parameter int PC_W     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_clr_i,
  input  logic             idx_inc_i,
  input  logic             pc_clr_i,
  input  logic             pc_inc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             last_o
);

  logic [IDX_W-1:0] idx_q;
  logic [PC_W-1:0]  pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      pc_q  <= PC_W'(1);
    end else begin
      if (idx_clr_i)      idx_q <= '0;
      else if (idx_inc_i) idx_q <= idx_q + IDX_W'(1);
      if (pc_clr_i)       pc_q  <= PC_W'(1);
      else if (pc_inc_i)  pc_q  <= pc_q + PC_W'(1);
    end
  end

  assign idx_o  = idx_q;
  assign pc_o   = pc_q;
  assign last_o = (idx_q == IDX_W'(NUM_SECT - 1));

  p_idx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(NUM_SECT - 1));

  p_pc_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q != '0);

endmodule

// File: rtl/sector_lock_seq.sv
module sector_lock_seq
  import sector_lock_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned NUM_SECT   = 19,
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned HV_US      = 1,
  parameter int unsigned LOCK_US    = 150,
  parameter int unsigned UNLOCK_US  = 15000,
  parameter int unsigned LOCK_MAX   = 25,
  parameter int unsigned UNLOCK_MAX = 1000,
  localparam int IDX_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              unlock_i,
  output logic [IDX_W-1:0]  sect_idx_o,
  input  logic [ADDR_W-1:0] sect_base_i,
  input  logic              sect_sel_i,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DQ_W-1:0]   flash_dq_o,
  input  logic [DQ_W-1:0]   flash_dq_i,
  output logic              flash_we_no,
  output logic              flash_oe_no,
  output logic              flash_ce_no,
  output logic              flash_hv_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [IDX_W-1:0]  fail_sect_o
);

  localparam int unsigned HV_CYC   = us_to_cycles(CLK_KHZ, HV_US);
  localparam int unsigned LOCK_CYC = us_to_cycles(CLK_KHZ, LOCK_US);
  localparam int unsigned UNL_CYC  = us_to_cycles(CLK_KHZ, UNLOCK_US);
  localparam int unsigned MAX_W1   = (LOCK_CYC > HV_CYC) ? LOCK_CYC : HV_CYC;
  localparam int unsigned MAX_CYC  = (UNL_CYC > MAX_W1) ? UNL_CYC : MAX_W1;
  localparam int TMR_W = $clog2(MAX_CYC + 1);
  localparam int unsigned PC_MAX = (UNLOCK_MAX > LOCK_MAX) ? UNLOCK_MAX : LOCK_MAX;
  localparam int PC_W = $clog2(PC_MAX + 1);

  seq_state_e        state_q, state_d;
  logic              unlock_mode_q;
  logic              pass_q;   // 0: lock pass, 1: unlock pass
  logic [IDX_W-1:0]  fail_sect_q;

  logic              bus_req, bus_wr, bus_ack;
  logic [ADDR_W-1:0] bus_addr, tgt_addr;
  logic [DQ_W-1:0]   bus_wdata, bus_rdata;
  logic              dir_bit;

  logic              idx_clr, idx_inc, pc_clr, pc_inc, last_sect;
  logic [IDX_W-1:0]  idx;
  logic [PC_W-1:0]   pc, pc_lim;

  logic              tmr_en, tmr_done;
  logic [TMR_W-1:0]  tmr_limit;

  logic              vfy_ok, idle_like;

  sector_lock_bus #(.ADDR_W(ADDR_W)) i_bus (
    .clk_i, .rst_ni,
    .req_i        (bus_req),
    .wr_i         (bus_wr),
    .addr_i       (bus_addr),
    .wdata_i      (bus_wdata),
    .ack_o        (bus_ack),
    .rdata_o      (bus_rdata),
    .flash_addr_o (flash_addr_o),
    .flash_dq_o   (flash_dq_o),
    .flash_dq_i   (flash_dq_i),
    .flash_we_no  (flash_we_no),
    .flash_oe_no  (flash_oe_no),
    .flash_ce_no  (flash_ce_no)
  );

  sector_lock_track #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W), .PC_W(PC_W)) i_track (
    .clk_i, .rst_ni,
    .idx_clr_i (idx_clr),
    .idx_inc_i (idx_inc),
    .pc_clr_i  (pc_clr),
    .pc_inc_i  (pc_inc),
    .idx_o     (idx),
    .pc_o      (pc),
    .last_o    (last_sect)
  );

  sector_lock_timer #(.CNT_W(TMR_W)) i_timer (
    .clk_i, .rst_ni,
    .en_i    (tmr_en),
    .limit_i (tmr_limit),
    .done_o  (tmr_done)
  );

  always_comb begin
    tgt_addr          = sect_base_i;
    tgt_addr[BIT_DIR] = dir_bit;
    tgt_addr[1]       = 1'b1;
    tgt_addr[0]       = 1'b0;
  end

  assign pc_lim    = pass_q ? PC_W'(UNLOCK_MAX) : PC_W'(LOCK_MAX);
  assign vfy_ok    = pass_q ? (bus_rdata == RD_OPEN) : (bus_rdata == RD_LOCKED);
  assign idle_like = (state_q == S_IDLE) || (state_q == S_DONE) || (state_q == S_FAIL);

  always_comb begin
    state_d   = state_q;
    bus_req   = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    dir_bit   = 1'b0;
    tmr_en    = 1'b0;
    tmr_limit = TMR_W'(HV_CYC);
    idx_clr   = 1'b0;
    idx_inc   = 1'b0;
    pc_clr    = 1'b0;
    pc_inc    = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: if (start_i) begin
        idx_clr = 1'b1;
        pc_clr  = 1'b1;
        state_d = S_HV_ON;
      end
      S_HV_ON: begin
        tmr_en = 1'b1;
        if (tmr_done) state_d = S_SEL;
      end
      S_SEL: begin
        if (pass_q)             state_d = S_PLS_W;
        else if (unlock_mode_q) state_d = S_CHK_W;
        else if (sect_sel_i)    state_d = S_PLS_W;
        else                    state_d = S_NEXT;
      end
      S_CHK_W: begin
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_VERIFY;
        if (bus_ack) state_d = S_CHK_R;
      end
      S_CHK_R: begin
        bus_req = 1'b1;
        if (bus_ack) state_d = (bus_rdata == RD_LOCKED) ? S_NEXT : S_PLS_W;
      end
      S_PLS_W: begin
        dir_bit   = pass_q;
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_PULSE;
        if (bus_ack) state_d = S_PLS_WAIT;
      end
      S_PLS_WAIT: begin
        tmr_en    = 1'b1;
        tmr_limit = pass_q ? TMR_W'(UNL_CYC) : TMR_W'(LOCK_CYC);
        if (tmr_done) state_d = S_VFY_W;
      end
      S_VFY_W: begin
        dir_bit   = pass_q;
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_VERIFY;
        if (bus_ack) state_d = S_VFY_R;
      end
      S_VFY_R: begin
        dir_bit = pass_q;
        bus_req = 1'b1;
        if (bus_ack) begin
          if (vfy_ok)            state_d = S_NEXT;
          else if (pc >= pc_lim) state_d = S_FAIL;
          else begin
            pc_inc  = 1'b1;
            state_d = S_PLS_W;
          end
        end
      end
      S_NEXT: begin
        pc_clr = 1'b1;
        if (!last_sect) begin
          idx_inc = 1'b1;
          state_d = S_SEL;
        end else if (unlock_mode_q && !pass_q) begin
          idx_clr = 1'b1;
          state_d = S_SEL;
        end else begin
          state_d = S_HV_OFF;
        end
      end
      S_HV_OFF: begin
        tmr_en = 1'b1;
        if (tmr_done) state_d = S_RST_CMD;
      end
      S_RST_CMD: begin
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_RESET;
        if (bus_ack) state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // reset command goes to address 0, everything else to the sector
  assign bus_addr = (state_q == S_RST_CMD) ? '0 : tgt_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_IDLE;
      unlock_mode_q <= 1'b0;
      pass_q        <= 1'b0;
      fail_sect_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idle_like && start_i) begin
        unlock_mode_q <= unlock_i;
        pass_q        <= 1'b0;
        fail_sect_q   <= '0;
      end
      if (state_q == S_NEXT && last_sect && unlock_mode_q && !pass_q)
        pass_q <= 1'b1;
      if (state_q == S_VFY_R && bus_ack && !vfy_ok && pc >= pc_lim)
        fail_sect_q <= idx;
    end
  end

  assign sect_idx_o  = idx;
  assign busy_o      = !idle_like;
  assign done_o      = (state_q == S_DONE);
  assign fail_o      = (state_q == S_FAIL);
  assign fail_sect_o = fail_sect_q;
  assign flash_hv_o  = state_q inside {S_HV_ON, S_SEL, S_CHK_W, S_CHK_R, S_PLS_W,
                                       S_PLS_WAIT, S_VFY_W, S_VFY_R, S_NEXT};

  p_pulse_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && flash_dq_o == CMD_PULSE) |-> (flash_addr_o[1:0] == 2'b10 && flash_hv_o));

  p_rst_cmd_hv_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && flash_dq_o == CMD_RESET) |-> (!flash_hv_o && flash_addr_o == '0));

  p_pc_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc <= pc_lim);

  p_fail_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (flash_ce_no && !flash_hv_o));

  p_fail_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> fail_o);

  p_done_fail_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  p_mode_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(unlock_mode_q));

endmodule

// File: tb/test_sector_lock_seq.sv
module test_sector_lock_seq;

  localparam int NS  = 4;
  localparam int AW  = 19;
  localparam int KHZ = 2;
  // ceil(us*KHZ/1000), minimum 1
  localparam int HV_W  = 1;
  localparam int LCK_W = 1;
  localparam int UNL_W = 30;

  typedef struct packed {
    logic            mode;
    logic [3:0]      sel;
    logic [3:0]      init;
    logic [3:0][5:0] np;
    logic [3:0][10:0] nu;
    logic            efail;
    logic [1:0]      eidx;
    logic [15:0]     epp;
    logic [15:0]     eup;
  } vec_t;

  // np/nu: pulses each sector (s3..s0) needs to lock/unlock
  localparam vec_t VECS [8] = '{
    '{1'b0, 4'hF, 4'h0, {6'd1, 6'd1, 6'd1, 6'd1}, {11'd1, 11'd1, 11'd1, 11'd1}, 1'b0, 2'd0, 16'd4, 16'd0},
    '{1'b0, 4'h5, 4'h0, {6'd9, 6'd2, 6'd9, 6'd3}, {11'd1, 11'd1, 11'd1, 11'd1}, 1'b0, 2'd0, 16'd5, 16'd0},
    '{1'b0, 4'hF, 4'h0, {6'd1, 6'd25, 6'd1, 6'd1}, {11'd1, 11'd1, 11'd1, 11'd1}, 1'b0, 2'd0, 16'd28, 16'd0},
    '{1'b0, 4'hF, 4'h0, {6'd1, 6'd1, 6'd26, 6'd1}, {11'd1, 11'd1, 11'd1, 11'd1}, 1'b1, 2'd1, 16'd26, 16'd0},
    '{1'b1, 4'h0, 4'hF, {6'd1, 6'd1, 6'd1, 6'd1}, {11'd1, 11'd2, 11'd3, 11'd1}, 1'b0, 2'd0, 16'd0, 16'd7},
    '{1'b1, 4'h0, 4'h5, {6'd2, 6'd1, 6'd4, 6'd1}, {11'd1, 11'd1, 11'd1, 11'd1}, 1'b0, 2'd0, 16'd6, 16'd4},
    '{1'b1, 4'h0, 4'hF, {6'd1, 6'd1, 6'd1, 6'd1}, {11'd1, 11'd1, 11'd1000, 11'd1}, 1'b0, 2'd0, 16'd0, 16'd1003},
    '{1'b1, 4'h0, 4'hF, {6'd1, 6'd1, 6'd1, 6'd1}, {11'd1, 11'd1001, 11'd1, 11'd1}, 1'b1, 2'd2, 16'd0, 16'd1002}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start, unlock;
  logic [1:0]    sect_idx;
  logic [AW-1:0] sect_base;
  logic          sect_sel;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_dq_o;
  logic [7:0]    f_dq_i;
  logic          f_we_n, f_oe_n, f_ce_n, f_hv;
  logic          busy, done, fail;
  logic [1:0]    fail_sect;

  vec_t        cur;
  logic [3:0]  prot;
  logic [7:0]  rd_q;
  int pcp [4];
  int pcu [4];
  int pp, up, vp, vu, f0, bad_addr, bad_hv, bad_gap, bad_f0;
  int cyc, hv_t, pend_t;
  logic pend, pend_hi, first_wr, hv_prev;
  int checks = 0;
  int errors = 0;

  assign sect_base = AW'(sect_idx) << 15;
  assign sect_sel  = cur.sel[sect_idx];
  assign f_dq_i    = rd_q;

  sector_lock_seq #(
    .ADDR_W(AW), .NUM_SECT(NS), .CLK_KHZ(KHZ)
  ) i_sector_lock_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .unlock_i(unlock),
    .sect_idx_o(sect_idx), .sect_base_i(sect_base), .sect_sel_i(sect_sel),
    .flash_addr_o(f_addr), .flash_dq_o(f_dq_o), .flash_dq_i(f_dq_i),
    .flash_we_no(f_we_n), .flash_oe_no(f_oe_n), .flash_ce_no(f_ce_n),
    .flash_hv_o(f_hv), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_sect_o(fail_sect)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // flash model: sample write strobes away from the clock edge
  always @(negedge clk) begin
    if (f_hv && !hv_prev) hv_t = cyc;
    hv_prev = f_hv;
    if (!f_ce_n && !f_we_n) begin
      automatic int s = int'(f_addr[16:15]);
      automatic logic [AW-1:0] exp_a = (AW'(s) << 15) | (AW'(f_addr[6]) << 6) | AW'(2);
      if (first_wr && (cyc - hv_t) < HV_W) bad_hv++;
      first_wr = 1'b0;
      if (f_dq_o == 8'h60) begin
        if (f_addr != exp_a) bad_addr++;
        if (!f_hv) bad_hv++;
        if (!f_addr[6]) begin
          pp++; pcp[s]++;
          if (pcp[s] >= int'(cur.np[s])) prot[s] = 1'b1;
        end else begin
          up++; pcu[s]++;
          if (pcu[s] >= int'(cur.nu[s])) prot[s] = 1'b0;
        end
        pend = 1'b1; pend_hi = f_addr[6]; pend_t = cyc;
      end else if (f_dq_o == 8'h40) begin
        if (f_addr != exp_a) bad_addr++;
        if (!f_hv) bad_hv++;
        if (f_addr[6]) vu++; else vp++;
        rd_q = prot[s] ? 8'h01 : 8'h00;
        if (pend && (cyc - pend_t) < (pend_hi ? UNL_W : LCK_W)) bad_gap++;
        pend = 1'b0;
      end else if (f_dq_o == 8'hF0) begin
        f0++;
        if (f_hv || f_addr != '0) bad_f0++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int k);
    automatic vec_t v = VECS[k];
    automatic int ce_low = 0;
    cur = v; prot = v.init;
    for (int i = 0; i < 4; i++) begin pcp[i] = 0; pcu[i] = 0; end
    pp = 0; up = 0; vp = 0; vu = 0; f0 = 0;
    bad_addr = 0; bad_hv = 0; bad_gap = 0; bad_f0 = 0;
    pend = 1'b0; first_wr = 1'b1;
    @(negedge clk); start = 1'b1; unlock = v.mode;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; unlock = ~v.mode;   // R10: must be ignored while busy
    @(negedge clk); start = 1'b0;
    while (!(done || fail)) @(negedge clk);
    chk("R5/R8 fail flag", int'(fail), int'(v.efail));
    chk("R8 done flag", int'(done), int'(!v.efail));
    chk("R4/R5 lock pulses", pp, int'(v.epp));
    chk("R7 unlock pulses", up, int'(v.eup));
    chk("R6 lock verifies", vp, v.mode ? NS + int'(v.epp) : int'(v.epp));
    chk("R7 unlock verifies", vu, int'(v.eup));
    chk("R3 address bits", bad_addr, 0);
    chk("R2 high voltage on writes", bad_hv, 0);
    chk("R3/R7 settle wait", bad_gap, 0);
    chk("R8 reset command count", f0, v.efail ? 0 : 1);
    chk("R8 reset command address/hv", bad_f0, 0);
    chk("R8/R5 hv off at end", int'(f_hv), 0);
    chk("R10 mode kept", int'(busy), 0);
    if (v.efail) begin
      chk("R5 failed sector", int'(fail_sect), int'(v.eidx));
      repeat (40) @(negedge clk) if (!f_ce_n) ce_low++;
      chk("R5 bus idle after fail", ce_low, 0);
      chk("R5 fail held", int'(fail), 1);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=busy expected=finished");
    report();
    $finish;
  end

  initial begin
    cyc = 0; hv_t = 0; pend_t = 0; hv_prev = 1'b0; rd_q = 8'hFF;
    cur = VECS[0]; prot = '0; first_wr = 1'b0; pend = 1'b0;
    pp = 0; up = 0; vp = 0; vu = 0; f0 = 0;
    bad_addr = 0; bad_hv = 0; bad_gap = 0; bad_f0 = 0;
    for (int i = 0; i < 4; i++) begin pcp[i] = 0; pcu[i] = 0; end
    rst_n = 1'b0; start = 1'b0; unlock = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hv", int'(f_hv), 0);
    chk("R1 ce", int'(f_ce_n), 1);
    chk("R1 we/oe", int'(f_we_n & f_oe_n), 1);
    chk("R1 busy/done/fail", int'({busy, done, fail}), 0);
    for (int k = 0; k < 8; k++) run_vec(k);
    // restart after a run that ended in fail
    run_vec(3);
    run_vec(0);
    report();
    $finish;
  end

endmodule